// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

A 16-bit up-counter that advances on a count-source tick while its run bit is set, shared by four general registers (channels 0 to 3). Each channel is set on its own either to latch the counter when its input pin shows a chosen edge, or to act on its output pin when the counter reaches the register value. Channel 2 can be made a history register for channel 0, and channel 3 for channel 1. In that mode, one edge leaves both the newest and the previous timestamp in hardware, so a pulse width or period is a single subtraction.

Software reaches the block through a single-cycle write port and a combinational read port. Event flags are set by the hardware and cleared by software, and an interrupt line is formed from the flags and their enables. Every input pin can be routed through a majority-free, all-equal noise filter that runs on the count-source tick. Each output pin has its own disable bit.

Top module: `ccu_timer`

## Requirements
- R1: The counter (address 5) advances by one on each cycle where `tick` is 1 and run (CTRL, address 0, bit 0) is 1. Otherwise it holds its value. A write to address 5 loads it.
- R2: A channel is in compare mode when bit 2 of its 3-bit mode code is 0. Mode codes sit in IOSEL (address 1), bits [4j+2:4j] for channel j. When the counter advances to a value equal to the channel's register (addresses 8+j), code 001 drives the pin level to 0, 010 to 1, 011 inverts it, and 000 leaves it unchanged. The level holds between matches.
- R3: A write to IOSEL loads each pin level from its initial-level bit, IOSEL bit 4j+3. That level stays on the pin until the first match.
- R4: A compare match fires once per pass of the counter through the register value. It sets flag j (FLAGS, address 4, bit j).
- R5: A counter step from FFFFh to 0000h sets the overflow flag (FLAGS bit 4).
- R6: With CTRL bit 1 set and channel 0 in compare mode, the step after the counter equals register 0 loads 0000h instead of incrementing. No overflow is flagged for that step.
- R7: In capture mode, mode code 100 captures on a rising edge, 101 on a falling edge, and 11x on both edges. A capture loads the counter value into the register and sets flag j. Without the filter, a pin change is captured two ticks later, holding the count from one tick after the change.
- R8: With CTRL bit 2 set, channel 2 has no events of its own. Each channel-0 capture moves the old register 0 into register 2 in the same cycle. CTRL bit 3 does the same for channel 1 and channel 3.
- R9: With filter bit j set (PINCFG, address 2, bit 4+j), a new pin level is accepted only after three consecutive equal tick samples. The capture then holds the count from four ticks after the change. A pulse of two samples is discarded.
- R10: Writing FLAGS clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A hardware set in the same cycle wins over a clear.
- R11: `irq` is 1 exactly when some flag is set while its enable bit (IRQEN, address 3, same bit positions as FLAGS) is set.
- R12: `ch_oe[j]` is 1 only when channel j is in compare mode and its disable bit (PINCFG bit j) is 0.
- R13: After reset, the counter is 0, all registers read FFFFh, all flags, enables, modes and levels are 0, and all pins are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-source enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ch_in | input | 4 | Channel input pins |
| ch_out | output | 4 | Channel output levels |
| ch_oe | output | 4 | Channel output drive enables |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following:
- the counter holds when not advancing;
- the counter lands on zero after a wrap or a channel-0 clear;
- the filtered level moves only on a tick;
- a buffered capture moves the old channel-0 value into channel 2;
- no hardware flag set is lost to a software clear.

Some behaviours can only be shown by the bench's scenarios, because they depend on exact latencies and on what the software wrote earlier. These are:
- the exact capture latency with and without the filter;
- a filtered glitch being rejected;
- the compare actions on top of an initial level;
- a match firing only once per pass;
- the clear-to-zero period.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int unsigned CCU_NCH       = 4;
  localparam int unsigned CCU_FLD       = 4;
  localparam int unsigned CCU_FLT_TAPS  = 3;

  typedef enum logic [3:0] {
    RA_CTRL  = 4'h0,
    RA_IOSEL = 4'h1,
    RA_PIN   = 4'h2,
    RA_IEN   = 4'h3,
    RA_FLAG  = 4'h4,
    RA_CNT   = 4'h5
  } reg_addr_e;

  // new pin level after a compare match
  function automatic logic f_cmp_level(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  // does the observed level change qualify as a capture edge
  function automatic logic f_edge_hit(input logic [1:0] sel, input logic prev, input logic now);
    case (sel)
      2'b00:   return ~prev & now;
      2'b01:   return prev & ~now;
      default: return prev ^ now;
    endcase
  endfunction
endpackage

// File: rtl/ccu_counter.sv
module ccu_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         clr_on_a,
  input  logic         a_is_cmp,
  input  logic [W-1:0] gr_a,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt_cnt,
  output logic         adv,
  output logic         ovf_evt,
  output logic         clr_evt
);
  localparam logic [W-1:0] TOP = '1;

  assign adv     = tick & run;
  assign clr_evt = adv & clr_on_a & a_is_cmp & (cnt == gr_a);
  assign ovf_evt = adv & ~clr_evt & (cnt == TOP);
  assign nxt_cnt = clr_evt ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= wr_val;
    else if (adv)    cnt <= nxt_cnt;
  end

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_cnt) |=> $stable(cnt));
  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !wr_cnt) |=> (cnt == '0));
  // R6
  clear_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !wr_cnt) |=> (cnt == '0));
endmodule

// File: rtl/ccu_in_filter.sv
module ccu_in_filter #(
  parameter int unsigned TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flt_en,
  input  logic pin,
  output logic lvl,
  output logic lvl_prev
);
  logic [TAPS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      lvl      <= 1'b0;
      lvl_prev <= 1'b0;
    end else if (tick) begin
      sh       <= {sh[TAPS-2:0], pin};
      lvl_prev <= lvl;
      if (!flt_en)  lvl <= pin;
      else if (&sh) lvl <= 1'b1;
      else if (~|sh) lvl <= 1'b0;
    end
  end

  // R9
  level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl));
endmodule

// File: rtl/ccu_timer.sv
module ccu_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [3:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [3:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [3:0]   ch_in,
  output logic [3:0]   ch_out,
  output logic [3:0]   ch_oe,
  output logic         irq
);
  import ccu_pkg::*;
  localparam int unsigned NCH = CCU_NCH;
  localparam int unsigned FLD = CCU_FLD;
  localparam int unsigned NFL = NCH + 1;

  logic           run, clr_a, buf_c, buf_d;
  logic [2:0]     mode [NCH];
  logic [NCH-1:0] init_lv, level, pin_off, flt;
  logic [NFL-1:0] ien, flags, flag_set;
  logic [W-1:0]   gr [NCH];
  logic [W-1:0]   cnt, nxt_cnt;
  logic           adv, ovf_evt, clr_evt;
  logic [NCH-1:0] lvl, lvl_prev, slave, cmp_evt, cap_evt, gr_wr, buf_load;
  logic [W-1:0]   buf_src [NCH];

  logic wr_ctrl, wr_iosel, wr_pin, wr_ien, wr_flag, wr_cnt;
  assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
  assign wr_iosel = wr_en && (wr_addr == RA_IOSEL);
  assign wr_pin   = wr_en && (wr_addr == RA_PIN);
  assign wr_ien   = wr_en && (wr_addr == RA_IEN);
  assign wr_flag  = wr_en && (wr_addr == RA_FLAG);
  assign wr_cnt   = wr_en && (wr_addr == RA_CNT);

  ccu_counter #(.W(W)) u_cnt (
    .clk, .rst_n, .tick, .run, .clr_on_a(clr_a), .a_is_cmp(~mode[0][2]),
    .gr_a(gr[0]), .wr_cnt, .wr_val(wr_data), .cnt, .nxt_cnt, .adv,
    .ovf_evt, .clr_evt
  );

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    ccu_in_filter #(.TAPS(CCU_FLT_TAPS)) u_flt (
      .clk, .rst_n, .tick, .flt_en(flt[j]), .pin(ch_in[j]),
      .lvl(lvl[j]), .lvl_prev(lvl_prev[j])
    );
    if (j >= 2) begin : g_buf
      assign slave[j]    = (j == 2) ? buf_c : buf_d;
      assign buf_load[j] = slave[j] & cap_evt[j-2];
      assign buf_src[j]  = gr[j-2];
    end else begin : g_nobuf
      assign slave[j]    = 1'b0;
      assign buf_load[j] = 1'b0;
      assign buf_src[j]  = gr[j];
    end
    assign gr_wr[j]   = wr_en && wr_addr[3] && !wr_addr[2] && (wr_addr[1:0] == 2'(j));
    assign cmp_evt[j] = ~mode[j][2] & ~slave[j] & adv & (nxt_cnt == gr[j]);
    assign cap_evt[j] = mode[j][2] & ~slave[j] & tick &
                        f_edge_hit(mode[j][1:0], lvl_prev[j], lvl[j]);
    assign ch_out[j]  = level[j];
    assign ch_oe[j]   = ~pin_off[j] & ~mode[j][2];
  end

  assign flag_set = {ovf_evt, cmp_evt | cap_evt};
  assign irq      = |(flags & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {buf_d, buf_c, clr_a, run} <= '0;
      pin_off <= '1;
      flt     <= '0;
      ien     <= '0;
      flags   <= '0;
      init_lv <= '0;
      level   <= '0;
      for (int j = 0; j < NCH; j++) begin
        mode[j] <= '0;
        gr[j]   <= '1;
      end
    end else begin
      if (wr_ctrl) {buf_d, buf_c, clr_a, run} <= wr_data[3:0];
      if (wr_pin) {flt, pin_off} <= wr_data[2*NCH-1:0];
      if (wr_ien) ien <= wr_data[NFL-1:0];
      flags <= (wr_flag ? (flags & wr_data[NFL-1:0]) : flags) | flag_set;
      for (int j = 0; j < NCH; j++) begin
        if (wr_iosel) begin
          mode[j]    <= wr_data[FLD*j +: 3];
          init_lv[j] <= wr_data[FLD*j+3];
          level[j]   <= wr_data[FLD*j+3];
        end else if (cmp_evt[j]) begin
          level[j] <= f_cmp_level(mode[j][1:0], level[j]);
        end
        if (gr_wr[j])         gr[j] <= wr_data;
        else if (cap_evt[j])  gr[j] <= cnt;
        else if (buf_load[j]) gr[j] <= buf_src[j];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL:  rd_data = W'({buf_d, buf_c, clr_a, run});
      RA_IOSEL: for (int j = 0; j < NCH; j++) rd_data[FLD*j +: FLD] = {init_lv[j], mode[j]};
      RA_PIN:   rd_data = W'({flt, pin_off});
      RA_IEN:   rd_data = W'(ien);
      RA_FLAG:  rd_data = W'(flags);
      RA_CNT:   rd_data = cnt;
      4'h8:     rd_data = gr[0];
      4'h9:     rd_data = gr[1];
      4'hA:     rd_data = gr[2];
      4'hB:     rd_data = gr[3];
      default:  rd_data = '0;
    endcase
  end

  // R8
  buffer_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt[0] && buf_c && !gr_wr[2]) |=> (gr[2] == $past(gr[0])));
  // R10
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));
endmodule

// File: tb/ccu_timer_bench.sv
`timescale 1ns/1ps
module ccu_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  ch_in = '0;
  logic [3:0]  ch_out, ch_oe;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ccu_timer u_ccu_timer (
    .clk, .rst_n, .tick, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .ch_in, .ch_out, .ch_oe, .irq
  );

  // {code[2:0], init, reg value[7:0], expected level}
  localparam logic [12:0] VEC [5] = '{
    13'b010_0_00000101_1,
    13'b001_1_00000110_0,
    13'b011_0_00000100_1,
    13'b011_1_00000011_0,
    13'b000_1_00000101_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v, c, c2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13 reset state
    chk("R13 oe", 32'(ch_oe), 32'h0);
    chk("R13 irq", 32'(irq), 32'h0);
    rd(4'h5, v); chk("R13 count", 32'(v), 32'h0);
    rd(4'h8, v); chk("R13 reg0", 32'(v), 32'hFFFF);

    // R1 hold and count
    wr(4'h5, 16'd100);
    waitn(10);
    rd(4'h5, v); chk("R1 hold stopped", 32'(v), 32'd100);
    wr(4'h0, 16'h1);
    waitn(7);
    rd(4'h5, v); chk("R1 counting", 32'(v), 32'd107);
    wr(4'h0, 16'h0);
    rd(4'h5, c);
    waitn(5);
    rd(4'h5, v); chk("R1 hold after stop", 32'(v), 32'(c));

    // R2 R3 R4 compare vectors on channel 1
    wr(4'h2, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      logic [12:0] e;
      e = VEC[i];
      wr(4'h0, 16'h0);
      wr(4'h5, 16'h0);
      wr(4'h1, {8'h00, e[9], e[12:10], 4'h0});
      wr(4'h9, {8'h00, e[8:1]});
      wr(4'h4, 16'h0);
      wr(4'h0, 16'h1);
      waitn(int'(e[8:1]) - 1);
      chk("R3 initial level", 32'(ch_out[1]), 32'(e[9]));
      chk("R12 compare pin driven", 32'(ch_oe[1]), 32'h1);
      waitn(1);
      chk("R2 match action", 32'(ch_out[1]), 32'(e[0]));
      rd(4'h4, v); chk("R4 match flag", 32'(v[1]), 32'h1);
    end

    // R5 overflow, R11 interrupt (channel 1 still code 000, value 5)
    wr(4'h0, 16'h0);
    wr(4'h5, 16'hFFFE);
    wr(4'h4, 16'h0);
    wr(4'h3, 16'h0010);
    wr(4'h0, 16'h1);
    waitn(2);
    rd(4'h5, v); chk("R5 wrap", 32'(v), 32'h0);
    rd(4'h4, v); chk("R5 overflow flag", 32'(v[4]), 32'h1);
    chk("R11 irq on overflow", 32'(irq), 32'h1);
    wr(4'h4, 16'h000F);
    rd(4'h4, v); chk("R10 clear by zero", 32'(v[4]), 32'h0);
    chk("R11 irq dropped", 32'(irq), 32'h0);
    waitn(10);
    rd(4'h4, v); chk("R4 flag 1 set", 32'(v[1]), 32'h1);
    chk("R11 masked flag", 32'(irq), 32'h0);
    wr(4'h3, 16'h0002);
    chk("R11 enabled flag", 32'(irq), 32'h1);
    wr(4'h3, 16'h0000);

    // R4 toggle fires once per pass (channel 3)
    wr(4'h0, 16'h0);
    wr(4'h1, 16'h3000);
    wr(4'hB, 16'd3);
    wr(4'h5, 16'h0);
    wr(4'h0, 16'h1);
    waitn(2);
    chk("R4 before match", 32'(ch_out[3]), 32'h0);
    waitn(1);
    chk("R4 toggled", 32'(ch_out[3]), 32'h1);
    waitn(30);
    chk("R4 single toggle", 32'(ch_out[3]), 32'h1);

    // R6 clear on channel 0 match
    wr(4'h0, 16'h0);
    wr(4'h1, 16'h0000);
    wr(4'h8, 16'd9);
    wr(4'h5, 16'h0);
    wr(4'h4, 16'h0);
    wr(4'h0, 16'h3);
    waitn(9);
    rd(4'h5, v); chk("R6 reaches value", 32'(v), 32'd9);
    rd(4'h4, v); chk("R6 flag 0", 32'(v[0]), 32'h1);
    waitn(1);
    rd(4'h5, v); chk("R6 cleared", 32'(v), 32'h0);
    waitn(9);
    rd(4'h5, v); chk("R6 period", 32'(v), 32'd9);
    rd(4'h4, v); chk("R6 no overflow", 32'(v[4]), 32'h0);

    // R10 hardware set wins over same-cycle clear (channel 3)
    wr(4'h0, 16'h0);
    wr(4'h1, 16'h2000);
    wr(4'hB, 16'd6);
    wr(4'h5, 16'h0);
    wr(4'h4, 16'h0);
    wr(4'h0, 16'h1);
    waitn(4);
    wr(4'h4, 16'h0);
    rd(4'h4, v); chk("R10 set wins", 32'(v[3]), 32'h1);
    wr(4'h4, 16'h0);
    rd(4'h4, v); chk("R10 later clear", 32'(v[3]), 32'h0);

    // R7 R8 falling capture with history, unfiltered, channel 0
    wr(4'h0, 16'h0);
    ch_in[0] = 1'b1;
    wr(4'h1, 16'h0505);
    wr(4'h8, 16'h1111);
    wr(4'h5, 16'd50);
    wr(4'h4, 16'h0);
    wr(4'h0, 16'h5);
    rd(4'h5, c);
    ch_in[0] = 1'b0;
    waitn(3);
    rd(4'h8, v); chk("R7 falling capture", 32'(v), 32'(c) + 1);
    rd(4'hA, v); chk("R8 history", 32'(v), 32'h1111);
    rd(4'h4, v); chk("R7 capture flag", 32'(v[0]), 32'h1);
    chk("R12 capture pin undriven", 32'(ch_oe[0]), 32'h0);
    ch_in[0] = 1'b1;
    waitn(4);
    rd(4'h8, v); chk("R7 rising ignored", 32'(v), 32'(c) + 1);
    rd(4'h5, c2);
    ch_in[0] = 1'b0;
    waitn(3);
    rd(4'h8, v); chk("R7 second capture", 32'(v), 32'(c2) + 1);
    rd(4'hA, v); chk("R8 history shift", 32'(v), 32'(c) + 1);

    // R9 filtered both-edge capture, channel 1
    wr(4'h0, 16'h0);
    wr(4'h1, 16'h0060);
    wr(4'h2, 16'h0020);
    wr(4'h9, 16'h0);
    wr(4'h5, 16'd200);
    wr(4'h0, 16'h1);
    waitn(5);
    rd(4'h5, c);
    ch_in[1] = 1'b1;
    waitn(4);
    rd(4'h9, v); chk("R9 not yet accepted", 32'(v), 32'h0);
    waitn(1);
    rd(4'h9, v); chk("R9 filtered capture", 32'(v), 32'(c) + 4);
    ch_in[1] = 1'b0;
    waitn(2);
    ch_in[1] = 1'b1;
    waitn(8);
    rd(4'h9, v); chk("R9 glitch rejected", 32'(v), 32'(c) + 4);
    rd(4'h5, c2);
    ch_in[1] = 1'b0;
    waitn(5);
    rd(4'h9, v); chk("R7 R9 both-edge capture", 32'(v), 32'(c2) + 4);

    // R12 disable bits
    wr(4'h1, 16'h0000);
    wr(4'h2, 16'h0002);
    chk("R12 disable", 32'(ch_oe), 32'hD);

    summary();
    $finish;
  end
endmodule